// File: doc/BRIEF.md
# ISA Refresh Sequencer with Short Host-Bus Hold

This block runs DRAM refresh cycles on an ISA-style expansion bus and keeps the host bus for as short a time as possible. A free-running interval counter raises a refresh request at a fixed rate. The sequencer then asks for the host bus, waits for the grant, and presents the refresh row address for exactly two host clocks. An external latch captures the address on a one-clock strobe. The host bus is then handed back while the ISA refresh command and the system memory read strobe request stay active for a set number of ISA clock ticks. After that the row counter advances.

When an add-on card has mastership of the ISA bus, the sequencer does not drive the refresh command line. It watches that line as an input instead, and a falling edge on it starts a refresh. This refresh uses the same address phase and row counter as an internal one. Internal periodic requests are held back while the card owns the bus, and are carried out once it lets go. ISA timing arrives as a one-clock `isa_tick` enable in the host clock domain. The refresh interval (host clocks), the command length (ISA ticks) and the row width are all parameters.

Top module: `isa_refresh_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `hold_req`, `addr_oe`, `addr_latch`, `ref_oe` and `smemr_req` are 0, `ref_n_out` is 1 and `row_addr` is 0.
- R2: In a refresh started by the internal timer, `ref_oe` is 1 and `ref_n_out` is 0 in every clock of the command phase (the clocks where `smemr_req` is 1).
- R3: Each refresh has an address phase where `addr_oe` is 1 for exactly two consecutive clocks. It begins only after `hold_gnt` has been seen high while `hold_req` is high. `addr_latch` is 1 in the second of those two clocks and in no other clock.
- R4: `hold_req` stays high from the request through the end of the address phase and is 0 in every clock of the command phase.
- R5: `smemr_req` is 1 for the whole command phase of every refresh, whatever the trigger source, and 0 outside it.
- R6: The command phase consumes exactly CMD_TICKS cycles in which `isa_tick` is high, then ends.
- R7: `row_addr` increases by one, modulo 2^ROW_W, in the same clock that `smemr_req` falls, and at no other time.
- R8: With `isa_master` low and an immediate grant, the first `hold_req` rises on the (INTERVAL+1)-th rising clock edge after reset is released. Later requests follow every INTERVAL clocks.
- R9: A pending periodic request is kept while the grant is withheld. Timer expiries that occur while a request is already pending merge into one further refresh.
- R10: With `isa_master` high, a falling edge on `ref_n_in` starts a refresh. In that refresh `ref_oe` stays 0 throughout, while R3 to R7 still hold.
- R11: While `isa_master` is high, no periodic refresh is started. A request raised in that time starts a refresh within three clocks of `isa_master` going low.
- R12: Falling edges on `ref_n_in` while a refresh is already in progress are ignored: they start no further refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_tick | input | 1 | One-clock enable marking each ISA clock period |
| isa_master | input | 1 | High while an add-on card owns the ISA bus |
| hold_gnt | input | 1 | Host bus grant |
| ref_n_in | input | 1 | Refresh command line as seen on the bus (active low) |
| hold_req | output | 1 | Host bus request |
| addr_oe | output | 1 | Drive the refresh row address onto the host bus |
| addr_latch | output | 1 | One-clock strobe for the external address latch |
| row_addr | output | ROW_W | Current refresh row address |
| ref_oe | output | 1 | Output enable of the refresh command driver |
| ref_n_out | output | 1 | Refresh command level to drive (active low) |
| smemr_req | output | 1 | Request for the system memory read strobe |

## Verification
A state machine that leaves its address phase a clock early or late shows up on the very next clock: `addr_oe` runs for one or three cycles, or `addr_latch` falls outside the second cycle. A fault in the pending flag shows up as a request that is lost while the grant is held back, or as an extra refresh after the bus is released. Both are seen within one refresh interval as a wrong number of `hold_req` rises. A wrong trigger source or a miscounted command phase shows up at the next fall of `smemr_req`: `ref_oe` is wrong, the number of ISA ticks is wrong, or `row_addr` has not moved by exactly one.

// File: rtl/isa_rfsh_pkg.sv
package isa_rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HREQ = 2'd1,
    ST_ADDR = 2'd2,
    ST_CMD  = 2'd3
  } rfsh_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic expire
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (expire) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)       row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
  import isa_rfsh_pkg::*;
#(
  parameter int CMD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic isa_tick,
  input  logic isa_master,
  input  logic hold_gnt,
  input  logic ref_n_in,
  input  logic per_expire,
  output logic hold_req,
  output logic addr_oe,
  output logic addr_latch,
  output logic ref_oe,
  output logic smemr_req,
  output logic done
);
  localparam int TCNT_W = (CMD_TICKS > 1) ? $clog2(CMD_TICKS) : 1;
  localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(CMD_TICKS - 1);

  rfsh_state_t      state, state_n;
  logic             ext_mode, ext_mode_n;
  logic             acnt, acnt_n;
  logic [TCNT_W-1:0] tcnt, tcnt_n;
  logic             pending;
  logic             ref_prev;
  logic             ext_fall;
  logic             start_int;

  assign ext_fall  = isa_master & ref_prev & ~ref_n_in;
  assign start_int = (state == ST_IDLE) & ~ext_fall & pending & ~isa_master;

  always_comb begin
    state_n    = state;
    ext_mode_n = ext_mode;
    acnt_n     = acnt;
    tcnt_n     = tcnt;
    done       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ext_fall) begin
          state_n    = ST_HREQ;
          ext_mode_n = 1'b1;
        end else if (start_int) begin
          state_n    = ST_HREQ;
          ext_mode_n = 1'b0;
        end
      end
      ST_HREQ: begin
        if (hold_gnt) begin
          state_n = ST_ADDR;
          acnt_n  = 1'b0;
        end
      end
      ST_ADDR: begin
        if (acnt) begin
          state_n = ST_CMD;
          tcnt_n  = '0;
        end else begin
          acnt_n = 1'b1;
        end
      end
      ST_CMD: begin
        if (isa_tick) begin
          if (tcnt == TLAST) begin
            state_n = ST_IDLE;
            done    = 1'b1;
          end else begin
            tcnt_n = tcnt + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ext_mode   <= 1'b0;
      acnt       <= 1'b0;
      tcnt       <= '0;
      pending    <= 1'b0;
      ref_prev   <= 1'b1;
      hold_req   <= 1'b0;
      addr_oe    <= 1'b0;
      addr_latch <= 1'b0;
      ref_oe     <= 1'b0;
      smemr_req  <= 1'b0;
    end else begin
      state      <= state_n;
      ext_mode   <= ext_mode_n;
      acnt       <= acnt_n;
      tcnt       <= tcnt_n;
      ref_prev   <= ref_n_in;
      if (start_int)       pending <= per_expire;
      else if (per_expire) pending <= 1'b1;
      hold_req   <= (state_n == ST_HREQ) || (state_n == ST_ADDR);
      addr_oe    <= (state_n == ST_ADDR);
      addr_latch <= (state_n == ST_ADDR) && acnt_n;
      ref_oe     <= (state_n == ST_CMD) && !ext_mode_n;
      smemr_req  <= (state_n == ST_CMD);
    end
  end
endmodule

// File: rtl/isa_refresh_seq.sv
module isa_refresh_seq #(
  parameter int INTERVAL  = 1024,
  parameter int CMD_TICKS = 4,
  parameter int ROW_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isa_tick,
  input  logic             isa_master,
  input  logic             hold_gnt,
  input  logic             ref_n_in,
  output logic             hold_req,
  output logic             addr_oe,
  output logic             addr_latch,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_oe,
  output logic             ref_n_out,
  output logic             smemr_req
);
  logic per_expire;
  logic done;
  logic ref_oe_q;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .expire (per_expire)
  );

  rfsh_seq_fsm #(.CMD_TICKS(CMD_TICKS)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .isa_tick   (isa_tick),
    .isa_master (isa_master),
    .hold_gnt   (hold_gnt),
    .ref_n_in   (ref_n_in),
    .per_expire (per_expire),
    .hold_req   (hold_req),
    .addr_oe    (addr_oe),
    .addr_latch (addr_latch),
    .ref_oe     (ref_oe_q),
    .smemr_req  (smemr_req),
    .done       (done)
  );

  rfsh_row_counter #(.ROW_W(ROW_W)) row_i (
    .clk  (clk),
    .rst  (rst),
    .step (done),
    .row  (row_addr)
  );

  assign ref_oe    = ref_oe_q;
  assign ref_n_out = ~ref_oe_q;
endmodule

// File: rtl/isa_refresh_seq_chk.sv
module isa_refresh_seq_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_gnt,
  input logic             hold_req,
  input logic             addr_oe,
  input logic             addr_latch,
  input logic [ROW_W-1:0] row_addr,
  input logic             ref_oe,
  input logic             ref_n_out,
  input logic             smemr_req
);
  // R3
  addr_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    addr_oe |-> hold_req);
  // R3
  addr_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_oe) |-> $past(hold_gnt));
  // R3
  addr_second_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_oe) |=> addr_oe);
  // R3
  addr_end_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_oe && $past(addr_oe)) |=> !addr_oe);
  // R3
  latch_slot_chk: assert property (@(posedge clk) disable iff (rst)
    addr_latch |-> (addr_oe && $past(addr_oe)));
  // R4
  bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    smemr_req |-> !hold_req);
  // R2
  drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    ref_oe |-> !ref_n_out);
  // R5
  smemr_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ref_oe |-> smemr_req);
  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(smemr_req) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));
  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(smemr_req) |-> $stable(row_addr));
endmodule

bind isa_refresh_seq isa_refresh_seq_chk #(.ROW_W(ROW_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .hold_gnt   (hold_gnt),
  .hold_req   (hold_req),
  .addr_oe    (addr_oe),
  .addr_latch (addr_latch),
  .row_addr   (row_addr),
  .ref_oe     (ref_oe),
  .ref_n_out  (ref_n_out),
  .smemr_req  (smemr_req)
);

// File: tb/isa_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module isa_refresh_seq_tb_top;
  localparam int INTERVAL  = 200;
  localparam int CMD_TICKS = 3;
  localparam int ROW_W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic isa_tick = 1'b0;
  logic isa_master = 1'b0;
  logic hold_gnt = 1'b0;
  logic ref_n_in = 1'b1;
  logic hold_req, addr_oe, addr_latch, ref_oe, ref_n_out, smemr_req;
  logic [ROW_W-1:0] row_addr;

  always #4 clk = ~clk;

  isa_refresh_seq #(.INTERVAL(INTERVAL), .CMD_TICKS(CMD_TICKS), .ROW_W(ROW_W)) dut_i (
    .clk(clk), .rst(rst), .isa_tick(isa_tick), .isa_master(isa_master),
    .hold_gnt(hold_gnt), .ref_n_in(ref_n_in), .hold_req(hold_req),
    .addr_oe(addr_oe), .addr_latch(addr_latch), .row_addr(row_addr),
    .ref_oe(ref_oe), .ref_n_out(ref_n_out), .smemr_req(smemr_req)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ISA tick: one clock high out of three
  initial begin
    forever begin
      repeat (2) @(posedge clk);
      #1 isa_tick = 1'b1;
      @(posedge clk);
      #1 isa_tick = 1'b0;
    end
  end

  // Grant responder with programmable delay
  int gnt_delay = 0;
  initial begin
    int wait_ctr;
    wait_ctr = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst || !hold_req) begin
        hold_gnt = 1'b0;
        wait_ctr = 0;
      end else if (!hold_gnt) begin
        if (wait_ctr >= gnt_delay) hold_gnt = 1'b1;
        else wait_ctr++;
      end
    end
  end

  // Per-refresh monitor
  bit exp_own = 1'b1;
  int req_rises = 0, done_cnt = 0;
  int addr_cyc, latch_cnt, latch_pos, tick_cnt, oe_cyc, cmd_cyc, hold_in_cmd;
  logic prev_req = 1'b0, prev_smemr = 1'b0;
  logic [ROW_W-1:0] last_row = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hold_req && !prev_req) begin
        req_rises++;
        addr_cyc = 0; latch_cnt = 0; latch_pos = 0;
        tick_cnt = 0; oe_cyc = 0; cmd_cyc = 0; hold_in_cmd = 0;
      end
      if (addr_oe) begin
        addr_cyc++;
        if (addr_latch) begin latch_cnt++; latch_pos = addr_cyc; end
      end
      if (smemr_req) begin
        cmd_cyc++;
        if (isa_tick) tick_cnt++;
        if (ref_oe && !ref_n_out) oe_cyc++;
        if (hold_req) hold_in_cmd++;
      end
      if (!smemr_req && prev_smemr) begin
        done_cnt++;
        chk(addr_cyc == 2, "R3 address phase length", addr_cyc, 2);
        chk(latch_cnt == 1 && latch_pos == 2, "R3 latch strobe position", latch_pos, 2);
        chk(hold_in_cmd == 0, "R4 host bus released in command", hold_in_cmd, 0);
        chk(cmd_cyc > 0, "R5 smemr during command", cmd_cyc, 1);
        chk(tick_cnt == CMD_TICKS, "R6 command length in ISA ticks", tick_cnt, CMD_TICKS);
        if (exp_own) chk(oe_cyc == cmd_cyc, "R2 own refresh drives command low", oe_cyc, cmd_cyc);
        else         chk(oe_cyc == 0, "R10 master refresh not driven", oe_cyc, 0);
        chk(row_addr == ROW_W'(last_row + 1'b1), "R7 row step", row_addr, ROW_W'(last_row + 1'b1));
        last_row = row_addr;
      end
      prev_req   = hold_req;
      prev_smemr = smemr_req;
    end
  end

  task automatic wait_done(input int target, input int limit);
    for (int i = 0; i < limit && done_cnt < target; i++) @(posedge clk);
  endtask

  task automatic ext_pulse();
    @(posedge clk); #1 ref_n_in = 1'b0;
    repeat (2) @(posedge clk);
    #1 ref_n_in = 1'b1;
  endtask

  // Vectors: bit 8 = extra falling edge during command, bits 7:0 = grant delay
  localparam logic [8:0] VEC [0:5] = '{9'h000, 9'h003, 9'h10A, 9'h001, 9'h11F, 9'h040};

  initial begin
    int n, r0, d0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!hold_req && !addr_oe && !addr_latch, "R1 reset bus outputs", {hold_req, addr_oe, addr_latch}, 0);
    chk(!ref_oe && ref_n_out && !smemr_req, "R1 reset command outputs", {ref_oe, ref_n_out, smemr_req}, 3'b010);
    chk(row_addr == 0, "R1 reset row", row_addr, 0);
    @(posedge clk); #1 rst = 1'b0;

    // R8 first periodic request
    n = 0;
    do begin @(posedge clk); n++; #1; end while (!hold_req && n < 1000);
    chk(n == INTERVAL + 1, "R8 first request edge", n, INTERVAL + 1);
    exp_own = 1'b1;
    wait_done(1, 100);
    chk(done_cnt == 1, "R2 first own refresh done", done_cnt, 1);

    // R9 grant withheld across two expiries
    gnt_delay = 450;
    r0 = req_rises;
    for (int i = 0; i < 400 && req_rises == r0; i++) @(posedge clk);
    for (int i = 0; i < 600 && !addr_oe; i++) @(posedge clk);
    gnt_delay = 0;
    wait_done(2, 100);
    chk(done_cnt == 2, "R9 delayed refresh completes", done_cnt, 2);
    repeat (40) @(posedge clk);
    chk(done_cnt == 3, "R9 merged requests give one refresh", done_cnt, 3);
    chk(req_rises == 3, "R9 request count", req_rises, 3);

    // R11 periodic requests deferred under ISA master
    isa_master = 1'b1;
    exp_own = 1'b0;
    r0 = req_rises;
    repeat (300) @(posedge clk);
    chk(req_rises == r0, "R11 no request while master", req_rises, r0);

    // R10 / R12 vector walk
    foreach (VEC[v]) begin
      gnt_delay = int'(VEC[v][7:0]);
      r0 = req_rises; d0 = done_cnt;
      ext_pulse();
      if (VEC[v][8]) begin
        for (int i = 0; i < 200 && !smemr_req; i++) @(posedge clk);
        ext_pulse();
      end
      wait_done(d0 + 1, 400);
      repeat (20) @(posedge clk);
      chk(done_cnt == d0 + 1, VEC[v][8] ? "R12 glitch ignored" : "R10 external trigger", done_cnt, d0 + 1);
      chk(req_rises == r0 + 1, "R10 one request per trigger", req_rises, r0 + 1);
    end
    gnt_delay = 0;

    // R7 wrap through a full row sweep
    d0 = done_cnt;
    for (int k = 0; k < 256; k++) begin
      ext_pulse();
      wait_done(d0 + k + 1, 100);
      repeat (2) @(posedge clk);
    end
    @(negedge clk);
    chk(done_cnt == d0 + 256, "R7 sweep count", done_cnt, d0 + 256);
    chk(row_addr == ROW_W'(done_cnt), "R7 row wraps modulo", row_addr, done_cnt % 256);

    // R11 deferred request fires after master release
    exp_own = 1'b1;
    r0 = req_rises;
    @(posedge clk); #1 isa_master = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_rises == r0 + 1, "R11 request after master release", req_rises, r0 + 1);
    wait_done(done_cnt + 1, 100);
    repeat (5) @(posedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule